// File: doc/BRIEF.md
# Serial Link Power State Controller

This block governs the power level of one transmit direction of a point-to-point serial link. It has three levels. In the active level the link carries data. In the light-sleep level only the data-lane drivers are switched off. In the deep-sleep level the clock and control circuitry is switched off as well. The surrounding logic raises single-cycle requests to sleep lightly, sleep deeply or wake. The block answers with two enables, one for the lane drivers and one for the core circuitry. It also reports whether the link may carry traffic.

A wake request always brings the link back to the active level. A down-counter then holds traffic back for a settling time. That time is set by one of two parameters: a short one for leaving light sleep and a longer one for leaving deep sleep. Outgoing data is passed through only while the link is usable. A sleep request that arrives during the settling time is remembered and carried out once the count has finished.

Top module: `link_pwr_ctrl`

## Requirements
- R1: `pwr_state` reports the current level with the encoding 0 = active, 1 = light sleep, 2 = deep sleep; the value 3 never appears.
- R2: While `rst_n` is low at a rising clock edge (synchronous, active low), the block goes to deep sleep with `lane_en`, `core_en`, `link_ready` and `tx_valid` all low.
- R3: In the active level `lane_en` and `core_en` are both 1. In light sleep `lane_en` is 0 and `core_en` is 1. In deep sleep both are 0.
- R4: In the active level with the count finished, `req_deep` moves to deep sleep at the next edge and wins over `req_light`. `req_light` alone moves to light sleep. `req_wake` has no effect.
- R5: In light sleep, `req_wake` moves to active and wins over `req_deep`. `req_deep` alone moves to deep sleep. `req_light` has no effect.
- R6: In deep sleep only `req_wake` has an effect and moves to active. `req_light` and `req_deep` are ignored.
- R7: When a wake request is sampled at clock edge k, `link_ready` stays low until edge k+WAKE_LIGHT (from light sleep) or edge k+WAKE_DEEP (from deep sleep) and is high after that edge.
- R8: `link_ready` is high only in the active level once the wake-up count has reached zero.
- R9: In the same cycle, `tx_valid` equals `data_valid_in` AND `link_ready`. `tx_data` equals `data_in` while `link_ready` is high and is zero otherwise.
- R10: Sleep requests that arrive while the wake-up count runs do not change the level. They are recorded, and at the edge that follows the first cycle with `link_ready` high the block enters deep sleep if any recorded request was deep, otherwise light sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_light | input | 1 | Request to enter light sleep |
| req_deep | input | 1 | Request to enter deep sleep |
| req_wake | input | 1 | Request to return to active |
| data_valid_in | input | 1 | Upstream data valid |
| data_in | input | DATA_W | Upstream data word |
| tx_valid | output | 1 | Gated data valid toward the lanes |
| tx_data | output | DATA_W | Gated data word toward the lanes |
| lane_en | output | 1 | Enable for the data-lane drivers |
| core_en | output | 1 | Enable for the clock and control circuitry |
| link_ready | output | 1 | Link usable for traffic |
| pwr_state | output | 2 | Current power level |

## Verification
Level changes and enables are registered, so they are due one edge after the request is sampled. `link_ready` is due exactly WAKE_LIGHT or WAKE_DEEP edges after the wake request. `tx_valid` and `tx_data` follow their inputs within the same cycle. The bench drives inputs on the falling edge and compares at the next falling edge, so each output is checked half a period after the edge that produced it. A bench model advances on the same rising edge as the design. The directed wake-latency checks count edges one by one, so a result that arrives one cycle early or late is caught.

// File: rtl/link_pwr_pkg.sv
// Shared types for the link power controller.
// Assumes: a 2-bit level code, with the values taken by the bench from the brief.
package link_pwr_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_LIGHT  = 2'd1,
        PS_DEEP   = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/lp_wake_timer.sv
// Wake-up settling counter. When load is high it takes the light or the deep
// latency, then counts down once per cycle to zero, where done is high.
// Assumes: LAT_DEEP > LAT_LIGHT >= 1, which the top module checks.
module lp_wake_timer #(
    parameter int LAT_LIGHT = 4,
    parameter int LAT_DEEP  = 12,
    localparam int CNT_W    = $clog2(LAT_DEEP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_deep,
    output logic done
);
    localparam logic [CNT_W-1:0] LIGHT_V = CNT_W'(LAT_LIGHT);
    localparam logic [CNT_W-1:0] DEEP_V  = CNT_W'(LAT_DEEP);

    logic [CNT_W-1:0] cnt_q;

    // Load on a wake request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= sel_deep ? DEEP_V : LIGHT_V;
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    // Finished flag.
    always_comb done = (cnt_q == '0);

    // R7
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/lp_state_fsm.sv
// Power level sequencer. It selects the next level from the requests and the
// state of the wake timer, and it records sleep requests that arrive during
// a wake-up count.
// Assumes: timer_done is low for at least one cycle after every wake_load.
module lp_state_fsm
    import link_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_light,
    input  logic       req_deep,
    input  logic       req_wake,
    input  logic       timer_done,
    output pwr_state_t state,
    output logic       wake_load,
    output logic       wake_deep
);
    pwr_state_t state_q, state_d;
    logic       pend_light_q, pend_deep_q;
    logic       counting;

    // The wake-up count is still running in the active level.
    always_comb counting = (state_q == PS_ACTIVE) && !timer_done;

    // Next-level selection and timer load.
    always_comb begin
        state_d   = state_q;
        wake_load = 1'b0;
        wake_deep = 1'b0;
        unique case (state_q)
            PS_ACTIVE: begin
                if (timer_done) begin
                    if (req_deep || pend_deep_q)        state_d = PS_DEEP;
                    else if (req_light || pend_light_q) state_d = PS_LIGHT;
                end
            end
            PS_LIGHT: begin
                if (req_wake) begin
                    state_d   = PS_ACTIVE;
                    wake_load = 1'b1;
                end else if (req_deep) begin
                    state_d = PS_DEEP;
                end
            end
            PS_DEEP: begin
                if (req_wake) begin
                    state_d   = PS_ACTIVE;
                    wake_load = 1'b1;
                    wake_deep = 1'b1;
                end
            end
            default: state_d = PS_DEEP;
        endcase
    end

    // Level register, reset to deep sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_DEEP;
        else        state_q <= state_d;
    end

    // Record sleep requests during a count and clear them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) begin
            pend_light_q <= 1'b0;
            pend_deep_q  <= 1'b0;
        end else begin
            pend_light_q <= pend_light_q | req_light;
            pend_deep_q  <= pend_deep_q  | req_deep;
        end
    end

    // Level output.
    always_comb state = state_q;

    // R6
    deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DEEP) |=> (state_q == PS_DEEP || state_q == PS_ACTIVE));
    // R5
    light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LIGHT && req_wake) |=> (state_q == PS_ACTIVE));
    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        counting |=> (state_q == PS_ACTIVE));
    // R10
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && req_deep) |=> pend_deep_q);
    // R1
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: rtl/lp_data_gate.sv
// Traffic gate. It passes the valid flag and the data word only while the link
// is usable and forces both to zero otherwise.
// Assumes: ready comes from registers, so the gate adds only one AND level.
module lp_data_gate #(
    parameter int DATA_W = 16
) (
    input  logic              ready,
    input  logic              vld_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              vld_out,
    output logic [DATA_W-1:0] data_out
);
    // One gate per data bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb data_out[b] = data_in[b] & ready;
    end

    // Gated valid.
    always_comb vld_out = vld_in & ready;
endmodule

// File: rtl/link_pwr_ctrl.sv
// Top of the link power controller. It connects the sequencer, the wake timer
// and the data gate, and it decodes the two power enables and the ready flag.
// Assumes: single clock and synchronous active-low reset; requests are sampled
// at every rising edge.
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WAKE_LIGHT = 4,
    parameter int WAKE_DEEP  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_light,
    input  logic              req_deep,
    input  logic              req_wake,
    input  logic              data_valid_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              lane_en,
    output logic              core_en,
    output logic              link_ready,
    output logic [1:0]        pwr_state
);
    if (!(WAKE_DEEP > WAKE_LIGHT && WAKE_LIGHT >= 1)) begin : g_bad_latency
        $error("deep wake latency must exceed light wake latency, both >= 1");
    end

    pwr_state_t st;
    logic       t_load, t_deep, t_done;

    lp_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_light  (req_light),
        .req_deep   (req_deep),
        .req_wake   (req_wake),
        .timer_done (t_done),
        .state      (st),
        .wake_load  (t_load),
        .wake_deep  (t_deep)
    );

    lp_wake_timer #(
        .LAT_LIGHT (WAKE_LIGHT),
        .LAT_DEEP  (WAKE_DEEP)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .sel_deep (t_deep),
        .done     (t_done)
    );

    // Enable and ready decode from the level and the timer.
    always_comb begin
        lane_en    = (st == PS_ACTIVE);
        core_en    = (st != PS_DEEP);
        link_ready = (st == PS_ACTIVE) && t_done;
        pwr_state  = st;
    end

    lp_data_gate #(.DATA_W(DATA_W)) u_gate (
        .ready    (link_ready),
        .vld_in   (data_valid_in),
        .data_in  (data_in),
        .vld_out  (tx_valid),
        .data_out (tx_data)
    );

    // R3
    enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en |-> core_en);
    // R8
    ready_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_ready |-> (lane_en && core_en));
    // R9
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ready |-> (!tx_valid && tx_data == '0));
    // R7
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $stable(pwr_state));
endmodule

// File: tb/sim_link_pwr_ctrl.sv
module sim_link_pwr_ctrl;
    localparam int DW = 16;
    localparam int WL = 4;
    localparam int WD = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_light, req_deep, req_wake, data_valid_in;
    logic [DW-1:0] data_in;
    logic          tx_valid, lane_en, core_en, link_ready;
    logic [DW-1:0] tx_data;
    logic [1:0]    pwr_state;

    int vecs = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    link_pwr_ctrl #(.DATA_W(DW), .WAKE_LIGHT(WL), .WAKE_DEEP(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_light(req_light), .req_deep(req_deep),
        .req_wake(req_wake), .data_valid_in(data_valid_in), .data_in(data_in),
        .tx_valid(tx_valid), .tx_data(tx_data), .lane_en(lane_en),
        .core_en(core_en), .link_ready(link_ready), .pwr_state(pwr_state)
    );

    // Reference model built from the requirements.
    int m_st = 2;
    int m_cnt = 0;
    bit m_pl = 1'b0, m_pd = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 2; m_cnt <= 0; m_pl <= 1'b0; m_pd <= 1'b0;
        end else begin
            case (m_st)
                0: if (m_cnt != 0) begin
                       m_cnt <= m_cnt - 1;
                       m_pd  <= m_pd | req_deep;
                       m_pl  <= m_pl | req_light;
                   end else begin
                       m_pd <= 1'b0; m_pl <= 1'b0;
                       if (req_deep || m_pd)       m_st <= 2;
                       else if (req_light || m_pl) m_st <= 1;
                   end
                1: begin
                       m_pd <= 1'b0; m_pl <= 1'b0;
                       if (req_wake)      begin m_st <= 0; m_cnt <= WL; end
                       else if (req_deep) m_st <= 2;
                   end
                default: if (req_wake) begin m_st <= 0; m_cnt <= WD; end
            endcase
        end
    end

    function automatic bit exp_ready(int st, int cnt);
        return (st == 0) && (cnt == 0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        req_light = 1'b0; req_deep = 1'b0; req_wake = 1'b0;
    endtask

    task automatic check_model();
        bit r;
        r = exp_ready(m_st, m_cnt);
        chk("R1/R4/R5/R6 level", pwr_state, m_st);
        chk("R3 lane_en", lane_en, m_st == 0);
        chk("R3 core_en", core_en, m_st != 2);
        chk("R8 link_ready", link_ready, r);
        chk("R9 tx_valid", tx_valid, data_valid_in & r);
        chk("R9 tx_data", tx_data, r ? data_in : '0);
    endtask

    task automatic wait_ready();
        for (int g = 0; g < 64 && !link_ready; g++) step();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; clear_reqs();
        data_valid_in = 1'b1; data_in = 16'h1234;
        @(negedge clk); step();
        // R2 reset state
        chk("R2 level", pwr_state, 2);
        chk("R2 lane_en", lane_en, 0);
        chk("R2 core_en", core_en, 0);
        chk("R2 link_ready", link_ready, 0);
        chk("R2 tx_valid", tx_valid, 0);
        rst_n = 1'b1; data_valid_in = 1'b0;
        step();

        // R6 requests ignored in deep sleep
        req_light = 1'b1; step(); clear_reqs();
        chk("R6 light ignored", pwr_state, 2);
        req_deep = 1'b1; step(); clear_reqs();
        chk("R6 deep ignored", pwr_state, 2);

        // R7 deep wake latency, counted edge by edge
        req_wake = 1'b1; step(); clear_reqs();
        chk("R3 active lane_en", lane_en, 1);
        chk("R3 active core_en", core_en, 1);
        for (int j = 0; j <= WD; j++) begin
            chk("R7 deep latency", link_ready, j == WD);
            if (j < WD) step();
        end

        // R9 data gating in the ready cycle
        data_valid_in = 1'b1; data_in = 16'hA5A5; #1;
        chk("R9 pass valid", tx_valid, 1);
        chk("R9 pass data", tx_data, 16'hA5A5);
        data_valid_in = 1'b0;

        // R4 wake has no effect when active
        req_wake = 1'b1; step(); clear_reqs();
        chk("R4 wake ignored level", pwr_state, 0);
        chk("R4 wake ignored ready", link_ready, 1);

        // R4 deep wins over light
        req_light = 1'b1; req_deep = 1'b1; step(); clear_reqs();
        chk("R4 deep priority", pwr_state, 2);

        req_wake = 1'b1; step(); clear_reqs();
        wait_ready();
        req_light = 1'b1; step(); clear_reqs();
        chk("R4 enter light", pwr_state, 1);
        chk("R3 light lane_en", lane_en, 0);
        chk("R3 light core_en", core_en, 1);
        req_light = 1'b1; step(); clear_reqs();
        chk("R5 light ignored", pwr_state, 1);

        // R5 wake wins over deep, then R7 light latency
        req_wake = 1'b1; req_deep = 1'b1; step(); clear_reqs();
        chk("R5 wake priority", pwr_state, 0);
        data_valid_in = 1'b1; data_in = 16'hFFFF; #1;
        chk("R9 blocked valid", tx_valid, 0);
        chk("R9 blocked data", tx_data, 0);
        data_valid_in = 1'b0;
        for (int j = 0; j <= WL; j++) begin
            chk("R7 light latency", link_ready, j == WL);
            if (j < WL) step();
        end

        // R10 sleep requests during the count are held, deep wins
        req_light = 1'b1; step(); clear_reqs();
        req_wake = 1'b1; step(); clear_reqs();
        req_light = 1'b1; step(); clear_reqs();
        chk("R10 held light", pwr_state, 0);
        req_deep = 1'b1; step(); clear_reqs();
        chk("R10 held deep", pwr_state, 0);
        wait_ready();
        chk("R10 ready before sleep", link_ready, 1);
        step();
        chk("R10 pending deep applied", pwr_state, 2);

        // R5 light to deep
        req_wake = 1'b1; step(); clear_reqs();
        wait_ready();
        req_light = 1'b1; step(); clear_reqs();
        req_deep = 1'b1; step(); clear_reqs();
        chk("R5 light to deep", pwr_state, 2);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            check_model();
            req_light     = ($urandom % 9) == 0;
            req_deep      = ($urandom % 13) == 0;
            req_wake      = ($urandom % 7) == 0;
            data_valid_in = $urandom % 2;
            data_in       = DW'($urandom);
            #1;
            check_model();
            step();
        end
        summary();
    end
endmodule